// File: doc/BRIEF.md
# Command-Addressed Display Memory Controller

This block holds a sixteen-byte display memory behind an eight-bit processor port. A write with the port address line high carries a command. The top three bits of that command pick the operation. A write or read with the address line low moves a data byte to or from the memory. The last read-display or write-display command sets the location that data access uses. That command also decides whether the location steps forward after each access.

Two further features shape the bytes. A write-mask command can protect either half of every byte the processor stores. The same command can also replace either half of the bytes seen by the display multiplexer with the current blank code. A clear command selects one of three blank codes and can fill the whole memory with it. The fill takes one location per clock, and a busy flag stays high for the whole fill. The scan side reads any location through its own combinational port, so it never competes with the processor.

Top module: `dispram_ctrl`

## Requirements
- R1: After reset the memory holds 0x00 everywhere, the access location is 0, no access mode is selected (so data accesses are ignored), `cpu_dout`, `disp_busy` and `fifo_clr_req` are 0, no nibble is protected or blanked, and the blank code is 0x00.
- R2: A write strobe with `cpu_a0`=1 is a command, and bits 7:5 give the opcode. 011 selects read mode and 100 selects write mode; for both, bits 3:0 load the access location and bit 4 enables auto-step. 101 is the mask command and 110 is the clear command. Opcodes 000, 001, 010 and 111 change nothing.
- R3: In write mode, a write strobe with `cpu_a0`=0 stores `cpu_din` at the access location. With auto-step set, the location then advances by one and wraps from 15 to 0. Without auto-step it stays where it is.
- R4: In read mode, a read strobe with `cpu_a0`=0 places the stored byte at the access location on `cpu_dout` after the next clock edge. `cpu_dout` holds that byte until the next accepted data read. Auto-step advances the location as in R3. Data reads outside read mode leave `cpu_dout` unchanged.
- R5: Mask command bit 2 protects bits 3:0 and bit 3 protects bits 7:4 of every later processor data write. A protected nibble keeps its stored value.
- R6: Mask command bit 0 replaces bits 3:0 and bit 1 replaces bits 7:4 of `scan_data` with the matching nibble of the current blank code. The stored bytes are not changed by this.
- R7: Every clear command sets the blank code from bits 3:2: 00 or 01 gives 0x00, 10 gives 0x20 and 11 gives 0xFF. `fifo_clr_req` is high for exactly the one cycle after a clear command that has bit 1 or bit 0 set, and low otherwise.
- R8: A clear command with bit 4 or bit 0 set raises `disp_busy` on the next edge. The block then writes the blank code to locations 0 to 15 in ascending order, one per cycle, and drops `disp_busy` after sixteen cycles.
- R9: While `disp_busy` is high, processor data writes and reads are ignored. The memory keeps only the fill values, the access location does not move, and `cpu_dout` holds.
- R10: `scan_data` follows `scan_addr` combinationally and shows the stored byte at that location, with blanking applied as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_a0 | input | 1 | 1 = command, 0 = data |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_din | input | 8 | Command or data byte from the processor |
| cpu_dout | output | 8 | Last byte read from the memory |
| disp_busy | output | 1 | Memory unavailable, fill in progress |
| fifo_clr_req | output | 1 | One-cycle request to clear the key queue |
| scan_addr | input | 4 | Scan-side location |
| scan_data | output | 8 | Scan-side byte, blanking applied |

## Verification
The scan port can read a location in the same cycle that a processor write or a fill step updates it. The bench looks at the scan port right after the edge that commits the update. Halfway through a fill it reads two locations on the scan port: the location just written must already show the blank code, and the next one must still show its old contents. Processor accesses are also fired while the fill runs, and the bench confirms they leave no trace in the memory, the access location or `cpu_dout`.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = 8;
    localparam int NIB_N  = 2;
    localparam int NIB_W  = DATA_W / NIB_N;
    localparam int SEL_W  = 2;

    localparam logic [2:0] OP_RD   = 3'b011;
    localparam logic [2:0] OP_WR   = 3'b100;
    localparam logic [2:0] OP_MASK = 3'b101;
    localparam logic [2:0] OP_CLR  = 3'b110;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

    typedef struct packed {
        logic              rd_sel;
        logic              wr_sel;
        logic              mask_sel;
        logic              clr_sel;
        logic              ai;
        logic [ADDR_W-1:0] addr;
        logic [NIB_N-1:0]  inh;
        logic [NIB_N-1:0]  blk;
        logic              fill;
        logic              fifo_clr;
        logic [SEL_W-1:0]  code_sel;
    } cmd_t;
endpackage

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
    import disp_pkg::*;
(
    input  logic [DATA_W-1:0] cmd_byte,
    output cmd_t              dec
);
    logic [2:0] op;

    always_comb begin
        op           = cmd_byte[7:5];
        dec.rd_sel   = (op == OP_RD);
        dec.wr_sel   = (op == OP_WR);
        dec.mask_sel = (op == OP_MASK);
        dec.clr_sel  = (op == OP_CLR);
        dec.ai       = cmd_byte[4];
        dec.addr     = cmd_byte[ADDR_W-1:0];
        // mask command: [3] protect high, [2] protect low, [1] blank high, [0] blank low
        dec.inh      = {cmd_byte[3], cmd_byte[2]};
        dec.blk      = {cmd_byte[1], cmd_byte[0]};
        // clear command: [4] fill, [3:2] code select, [1] queue clear, [0] fill + queue clear
        dec.fill     = cmd_byte[4] | cmd_byte[0];
        dec.fifo_clr = cmd_byte[1] | cmd_byte[0];
        dec.code_sel = cmd_byte[3:2];
    end
endmodule

// File: rtl/disp_blank_code.sv
module disp_blank_code
    import disp_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] code
);
    always_comb begin
        case (sel)
            2'b10:   code = DATA_W'(8'h20);
            2'b11:   code = {DATA_W{1'b1}};
            default: code = '0;
        endcase
    end
endmodule

// File: rtl/disp_nibble_merge.sv
module disp_nibble_merge #(
    parameter int NW = 4,
    parameter int NN = 2
) (
    input  logic [NW*NN-1:0] keep_val,
    input  logic [NW*NN-1:0] new_val,
    input  logic [NN-1:0]    keep,
    output logic [NW*NN-1:0] merged
);
    for (genvar g = 0; g < NN; g++) begin : g_nib
        assign merged[g*NW +: NW] = keep[g] ? keep_val[g*NW +: NW] : new_val[g*NW +: NW];
    end
endmodule

// File: rtl/dispram_ctrl.sv
module dispram_ctrl
    import disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_a0,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_din,
    output logic [DATA_W-1:0] cpu_dout,
    output logic              disp_busy,
    output logic              fifo_clr_req,
    input  logic [ADDR_W-1:0] scan_addr,
    output logic [DATA_W-1:0] scan_data
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [ADDR_W-1:0]            addr;
        logic                         ai;
        acc_e                         mode;
        logic [NIB_N-1:0]             inh;
        logic [NIB_N-1:0]             blk;
        logic [SEL_W-1:0]             code_sel;
        logic                         du;
        logic [ADDR_W-1:0]            fill_ptr;
        logic [DATA_W-1:0]            dout;
        logic                         fifo_clr;
    } state_t;

    state_t            st_d, st_q;
    cmd_t              dec;
    logic [DATA_W-1:0] blank_code;
    logic [DATA_W-1:0] cur_byte;
    logic [DATA_W-1:0] wr_byte;
    logic              cmd_stb;
    logic              data_wr;
    logic              data_rd;

    disp_cmd_decode u_dec (
        .cmd_byte (cpu_din),
        .dec      (dec)
    );

    disp_blank_code u_code (
        .sel  (st_q.code_sel),
        .code (blank_code)
    );

    assign cur_byte = st_q.mem[st_q.addr];

    // processor write path: protected nibbles keep the stored value
    disp_nibble_merge #(.NW(NIB_W), .NN(NIB_N)) u_inh (
        .keep_val (cur_byte),
        .new_val  (cpu_din),
        .keep     (st_q.inh),
        .merged   (wr_byte)
    );

    // scan path: blanked nibbles show the blank code
    disp_nibble_merge #(.NW(NIB_W), .NN(NIB_N)) u_blk (
        .keep_val (blank_code),
        .new_val  (st_q.mem[scan_addr]),
        .keep     (st_q.blk),
        .merged   (scan_data)
    );

    assign cmd_stb = cpu_wr & cpu_a0;
    assign data_wr = cpu_wr & ~cpu_a0 & ~st_q.du & (st_q.mode == ACC_WR);
    assign data_rd = cpu_rd & ~cpu_a0 & ~st_q.du & (st_q.mode == ACC_RD);

    always_comb begin
        st_d          = st_q;
        st_d.fifo_clr = 1'b0;

        if (st_q.du) begin
            st_d.mem[st_q.fill_ptr] = blank_code;
            st_d.fill_ptr           = st_q.fill_ptr + 1'b1;
            if (st_q.fill_ptr == ADDR_W'(DEPTH - 1)) begin
                st_d.du = 1'b0;
            end
        end

        if (data_wr) begin
            st_d.mem[st_q.addr] = wr_byte;
            if (st_q.ai) begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end

        if (data_rd) begin
            st_d.dout = cur_byte;
            if (st_q.ai) begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end

        if (cmd_stb) begin
            if (dec.rd_sel || dec.wr_sel) begin
                st_d.mode = dec.rd_sel ? ACC_RD : ACC_WR;
                st_d.addr = dec.addr;
                st_d.ai   = dec.ai;
            end
            if (dec.mask_sel) begin
                st_d.inh = dec.inh;
                st_d.blk = dec.blk;
            end
            if (dec.clr_sel) begin
                st_d.code_sel = dec.code_sel;
                st_d.fifo_clr = dec.fifo_clr;
                if (dec.fill) begin
                    st_d.du       = 1'b1;
                    st_d.fill_ptr = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mem: '0, addr: '0, ai: 1'b0, mode: ACC_NONE, inh: '0,
                      blk: '0, code_sel: '0, du: 1'b0, fill_ptr: '0,
                      dout: '0, fifo_clr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_dout     = st_q.dout;
    assign disp_busy    = st_q.du;
    assign fifo_clr_req = st_q.fifo_clr;
endmodule

// File: rtl/dispram_ctrl_chk.sv
module dispram_ctrl_chk
    import disp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_a0,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_din,
    input logic [DATA_W-1:0] cpu_dout,
    input logic              disp_busy,
    input logic              fifo_clr_req
);
    localparam int CNT_W = ADDR_W + 1;

    logic             clr_cmd;
    logic             fill_cmd;
    logic             qclr_cmd;
    logic [CNT_W-1:0] busy_cnt;

    assign clr_cmd  = cpu_wr & cpu_a0 & (cpu_din[7:5] == OP_CLR);
    assign fill_cmd = clr_cmd & (cpu_din[4] | cpu_din[0]);
    assign qclr_cmd = clr_cmd & (cpu_din[1] | cpu_din[0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (fill_cmd) begin
            busy_cnt <= '0;
        end else if (disp_busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_fifo_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        qclr_cmd |=> fifo_clr_req);

    assert_fifo_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !qclr_cmd |=> !fifo_clr_req);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cmd |=> disp_busy);

    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_busy) |-> (busy_cnt == CNT_W'(DEPTH)));

    assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_busy && cpu_rd && !cpu_a0) |=> $stable(cpu_dout));
endmodule

bind dispram_ctrl dispram_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_a0       (cpu_a0),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .cpu_din      (cpu_din),
    .cpu_dout     (cpu_dout),
    .disp_busy    (disp_busy),
    .fifo_clr_req (fifo_clr_req)
);

// File: tb/sim_dispram_ctrl.sv
`timescale 1ns/1ps
module sim_dispram_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_a0 = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_din = '0;
    logic [7:0] cpu_dout;
    logic       disp_busy;
    logic       fifo_clr_req;
    logic [3:0] scan_addr = '0;
    logic [7:0] scan_data;

    int total = 0;
    int bad = 0;

    // bench model
    logic [7:0] m_mem [16];
    logic [3:0] m_addr;
    bit         m_ai;
    int         m_mode;     // 0 none, 1 read, 2 write
    logic [1:0] m_inh, m_blk, m_sel;
    logic [7:0] m_dout;

    always #2.5 clk = ~clk;

    dispram_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_a0       (cpu_a0),
        .cpu_wr       (cpu_wr),
        .cpu_rd       (cpu_rd),
        .cpu_din      (cpu_din),
        .cpu_dout     (cpu_dout),
        .disp_busy    (disp_busy),
        .fifo_clr_req (fifo_clr_req),
        .scan_addr    (scan_addr),
        .scan_data    (scan_data)
    );

    function automatic logic [7:0] f_code(input logic [1:0] s);
        return (s == 2'b10) ? 8'h20 : (s == 2'b11) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] f_keep(input logic [7:0] kv, input logic [7:0] nv,
                                          input logic [1:0] k);
        return {k[1] ? kv[7:4] : nv[7:4], k[0] ? kv[3:0] : nv[3:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 16; a++) begin
            scan_addr = 4'(a);
            #1;
            check(scan_data == f_keep(f_code(m_sel), m_mem[a], m_blk), tag,
                  scan_data, f_keep(f_code(m_sel), m_mem[a], m_blk));
        end
    endtask

    task automatic do_wr(input logic [7:0] b);
        cpu_wr = 1'b1; cpu_a0 = 1'b0; cpu_din = b;
        tick();
        cpu_wr = 1'b0;
        if (m_mode == 2) begin
            m_mem[m_addr] = f_keep(m_mem[m_addr], b, m_inh);
            if (m_ai) m_addr = m_addr + 1'b1;
        end
    endtask

    task automatic do_rd();
        cpu_rd = 1'b1; cpu_a0 = 1'b0;
        tick();
        cpu_rd = 1'b0;
        if (m_mode == 1) begin
            m_dout = m_mem[m_addr];
            if (m_ai) m_addr = m_addr + 1'b1;
        end
        check(cpu_dout == m_dout, "R4 data read", cpu_dout, m_dout);
    endtask

    task automatic do_cmd(input logic [7:0] b);
        cpu_wr = 1'b1; cpu_a0 = 1'b1; cpu_din = b;
        tick();
        cpu_wr = 1'b0; cpu_a0 = 1'b0;
        case (b[7:5])
            3'b011: begin m_mode = 1; m_addr = b[3:0]; m_ai = b[4]; end
            3'b100: begin m_mode = 2; m_addr = b[3:0]; m_ai = b[4]; end
            3'b101: begin m_inh = b[3:2]; m_blk = b[1:0]; end
            3'b110: begin
                m_sel = b[3:2];
                check(fifo_clr_req == (b[1] | b[0]), "R7 queue clear pulse",
                      8'(fifo_clr_req), 8'(b[1] | b[0]));
                check(disp_busy == (b[4] | b[0]), "R8 busy after clear",
                      8'(disp_busy), 8'(b[4] | b[0]));
                if (b[4] | b[0]) run_fill();
            end
            default: ;
        endcase
    endtask

    task automatic run_fill();
        for (int i = 0; i < 16; i++) begin
            if (i < 15) begin
                cpu_a0 = 1'b0;
                if ($urandom_range(0, 1) == 0) begin
                    cpu_wr = 1'b1; cpu_din = 8'($urandom);
                end else begin
                    cpu_rd = 1'b1;
                end
            end
            tick();
            cpu_wr = 1'b0; cpu_rd = 1'b0;
            if (i == 7) begin
                scan_addr = 4'd7;
                #1;
                check(scan_data == f_keep(f_code(m_sel), f_code(m_sel), m_blk),
                      "R8 fill reached location", scan_data, f_code(m_sel));
                scan_addr = 4'd8;
                #1;
                check(scan_data == f_keep(f_code(m_sel), m_mem[8], m_blk),
                      "R10 location not yet filled", scan_data,
                      f_keep(f_code(m_sel), m_mem[8], m_blk));
            end
            if (i == 14) check(disp_busy == 1'b1, "R8 busy held", 8'(disp_busy), 8'd1);
        end
        check(disp_busy == 1'b0, "R8 busy released", 8'(disp_busy), 8'd0);
        check(cpu_dout == m_dout, "R9 dout held during fill", cpu_dout, m_dout);
        for (int a = 0; a < 16; a++) m_mem[a] = f_code(m_sel);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int a = 0; a < 16; a++) m_mem[a] = 8'h00;
        m_addr = '0; m_ai = 1'b0; m_mode = 0;
        m_inh = '0; m_blk = '0; m_sel = '0; m_dout = '0;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(disp_busy == 1'b0, "R1 busy at reset", 8'(disp_busy), 8'd0);
        check(fifo_clr_req == 1'b0, "R1 queue clear at reset", 8'(fifo_clr_req), 8'd0);
        check(cpu_dout == 8'h00, "R1 dout at reset", cpu_dout, 8'h00);
        sweep("R1 memory at reset");
        do_wr(8'h55);           // no mode yet: ignored
        do_rd();
        sweep("R1 data ignored without mode");

        // R3 auto-step with wrap
        do_cmd(8'b100_1_1111);
        do_wr(8'hA1);
        do_wr(8'hB2);
        check(m_mem[0] == 8'hB2, "R3 model wrap", m_mem[0], 8'hB2);
        sweep("R3 write with wrap");
        do_cmd(8'b100_0_0101);
        do_wr(8'h11);
        do_wr(8'h22);
        sweep("R3 write without step");

        // R5 nibble protection
        do_cmd(8'b101_0_0100);
        do_cmd(8'b100_0_0110);
        do_wr(8'hC3);
        do_cmd(8'b101_0_1000);
        do_wr(8'h5D);
        sweep("R5 protected nibbles");
        do_cmd(8'b101_0_0000);

        // R6/R7 codes and blanking
        do_cmd(8'b110_0_1000);
        do_cmd(8'b101_0_0010);
        sweep("R6 high nibble blanked with 0x20");
        do_cmd(8'b101_0_0001);
        sweep("R6 low nibble blanked");
        do_cmd(8'b101_0_0000);
        do_cmd(8'b110_1_1100);
        sweep("R7 fill with 0xFF");
        do_cmd(8'b110_0_0001);
        sweep("R7 full clear with 0x00");
        do_cmd(8'b110_0_0010);
        check(disp_busy == 1'b0, "R7 queue-only clear keeps memory", 8'(disp_busy), 8'd0);

        // R4 read with wrap, R2 ignored opcodes
        do_cmd(8'b100_1_1110);
        do_wr(8'h3C); do_wr(8'h4D); do_wr(8'h5E);
        do_cmd(8'b011_1_1110);
        do_rd();
        do_cmd(8'b000_1_0011);
        do_cmd(8'b001_0_0001);
        do_cmd(8'b010_1_1111);
        do_cmd(8'b111_1_0101);
        do_rd();
        do_rd();
        sweep("R2 ignored opcodes");

        // R9 accesses during fill leave location untouched
        do_cmd(8'b110_1_0000);
        do_rd();

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [4:0] low5;
            r = $urandom_range(0, 99);
            low5 = 5'($urandom);
            if (r < 10) do_cmd({3'b011, low5});
            else if (r < 20) do_cmd({3'b100, low5});
            else if (r < 28) do_cmd({3'b101, 1'b0, low5[3:0]});
            else if (r < 31) do_cmd({3'b110, low5});
            else if (r < 34) begin
                logic [2:0] jop;
                case ($urandom_range(0, 3))
                    0: jop = 3'b000;
                    1: jop = 3'b001;
                    2: jop = 3'b010;
                    default: jop = 3'b111;
                endcase
                do_cmd({jop, low5});
            end
            else if (r < 67) do_wr(8'($urandom));
            else do_rd();
            if (n % 40 == 39) sweep("R10 scan view after random mix");
        end
        sweep("R10 final scan view");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule